// File: doc/BRIEF.md
# CAN Error Status Capture Register

This block is the error and status register that sits beside a CAN protocol engine and faces a host. Each clock cycle the engine may pulse any of six error strobes. The block picks one of them by a fixed priority, turns it into a 3-bit code and holds that code until the host reads the register. A held error is never overwritten. The code can be loaded only while it reads "clean frame" (000) or "nothing new" (111), so the first error after a read is the one software sees.

The same register also holds a transfer-success flag. The engine sets it with a strobe, and the host can write it. The host can force a status-change interrupt by writing the flag from 0 to 1. A single sticky interrupt line reports accepted errors and success events while the interrupt is enabled. A host read clears that line. While the software-init mode input is high, host reads leave the error code untouched.

Top module: `can_err_status`

## Requirements
- R1: After reset, the register reads 8'h07: error code 111, success flag 0, all other bits 0. The interrupt output is low.
- R2: The read data carries the error code in bits [2:0] and the success flag in bit 3, with the upper bits at 0. An error accepted in cycle N shows its code from cycle N+1. The codes are: stuff 001, format 010, no-acknowledge 011, bit-1 100, bit-0 101, CRC 110.
- R3: A host read with the software-init input low sets the code to 111 on the next cycle. With software-init high, a read leaves the code unchanged.
- R4: An error is accepted only while the code is 000 or 111. While the code holds any other value, new errors are dropped and the code stays the same.
- R5: An accepted error sets the interrupt when the interrupt enable is high. A dropped error never sets it, and the interrupt never rises without an event while enabled.
- R6: When several errors arrive in the same cycle, the code takes the highest-priority one. The order from highest to lowest is bit-0, stuff, CRC, no-acknowledge, format, bit-1.
- R7: A clean-frame strobe while the code is 111 or 000 loads 000 and raises no interrupt. A simultaneous error or host read (with software-init low) takes precedence.
- R8: A success strobe sets the flag whatever its previous value. It counts as a status-change event and sets the enabled interrupt.
- R9: A host write of 1 to bit 3 while the flag is 0 sets the flag and counts as an event. Writing 1 while the flag is already 1 is not an event. Writing 0 clears the flag and is not an event. A success strobe in the same cycle wins over a write.
- R10: Host writes to bits [2:0] have no effect on the error code.
- R11: The interrupt is a sticky level that a host read clears. An enabled event in the same cycle as the read keeps it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_rd | input | 1 | Host read strobe for the register |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 8 | Host write data; bit 3 is the success flag |
| host_rdata | output | 8 | Register contents |
| err_bit0 | input | 1 | Dominant bit sent, recessive bit seen |
| err_stuff | input | 1 | Bit stuffing violation |
| err_crc | input | 1 | CRC mismatch |
| err_noack | input | 1 | Transmitted frame not acknowledged |
| err_form | input | 1 | Frame format violation |
| err_bit1 | input | 1 | Recessive bit sent, dominant bit seen |
| frame_clean | input | 1 | Frame finished with no error |
| succ_strobe | input | 1 | Successful transmit or receive |
| swinit | input | 1 | Software-init mode; reads do not clear the code |
| irq_en | input | 1 | Interrupt enable |
| irq | output | 1 | Sticky interrupt request |

## Verification
The priority encoder is exercised in three ways: with each strobe on its own, with all six strobes together, and with partial groups whose top member changes from group to group. The single-strobe cases show that the codes themselves are correct. The grouped cases show that the ordering is correct and not just that something gets picked. Errors are also sent while a code is being held, and again right after a read with software-init high and with it low. This separates dropping an error from overwriting the held one, and a real clear from a read that is ignored. Last, random cycles mix reads, writes, success strobes and clean-frame strobes against a reference model, which reaches the coincidences of events with a read and of a write with a strobe.

// File: rtl/can_err_pkg.sv
package can_err_pkg;

  typedef enum logic [2:0] {
    CODE_CLEAN = 3'b000,
    CODE_STUFF = 3'b001,
    CODE_FORM  = 3'b010,
    CODE_NOACK = 3'b011,
    CODE_BIT1  = 3'b100,
    CODE_BIT0  = 3'b101,
    CODE_CRC   = 3'b110,
    CODE_NOCHG = 3'b111
  } err_code_e;

  // Member order is priority order, highest first.
  typedef struct packed {
    logic bit0;
    logic stuff;
    logic crc;
    logic noack;
    logic form;
    logic bit1;
  } err_vec_t;

  function automatic err_code_e pick_code(err_vec_t v);
    if (v.bit0)       return CODE_BIT0;
    else if (v.stuff) return CODE_STUFF;
    else if (v.crc)   return CODE_CRC;
    else if (v.noack) return CODE_NOACK;
    else if (v.form)  return CODE_FORM;
    else if (v.bit1)  return CODE_BIT1;
    else              return CODE_NOCHG;
  endfunction

  function automatic logic code_idle(err_code_e c);
    return (c == CODE_CLEAN) || (c == CODE_NOCHG);
  endfunction

endpackage

// File: rtl/err_code_latch.sv
module err_code_latch
  import can_err_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  err_vec_t  err_v,
  input  logic      clean_in,
  input  logic      rd_clr,
  output err_code_e code,
  output logic      accept
);
  err_code_e code_q;
  logic      idle;

  assign idle   = code_idle(code_q);
  assign accept = (|err_v) && idle;
  assign code   = code_q;

  // Precedence: accepted error, then read clear, then clean frame.
  always_ff @(posedge clk) begin
    if (!rst_n)
      code_q <= CODE_NOCHG;
    else if (accept)
      code_q <= pick_code(err_v);
    else if (rd_clr)
      code_q <= CODE_NOCHG;
    else if (clean_in && idle)
      code_q <= CODE_CLEAN;
  end
endmodule

// File: rtl/succ_flag_reg.sv
module succ_flag_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic wr_en,
  input  logic wr_bit,
  output logic flag,
  output logic evt
);
  logic flag_q;

  assign flag = flag_q;
  assign evt  = strobe || (wr_en && wr_bit && !flag_q);

  always_ff @(posedge clk) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (strobe) flag_q <= 1'b1;
    else if (wr_en)  flag_q <= wr_bit;
  end
endmodule

// File: rtl/irq_sticky.sv
module irq_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic ev,
  input  logic en,
  input  logic rd,
  output logic irq
);
  logic irq_q;

  assign irq = irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        irq_q <= 1'b0;
    else if (ev && en) irq_q <= 1'b1;
    else if (rd)       irq_q <= 1'b0;
  end
endmodule

// File: rtl/can_err_status.sv
module can_err_status
  import can_err_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SUCC_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              err_bit0,
  input  logic              err_stuff,
  input  logic              err_crc,
  input  logic              err_noack,
  input  logic              err_form,
  input  logic              err_bit1,
  input  logic              frame_clean,
  input  logic              succ_strobe,
  input  logic              swinit,
  input  logic              irq_en,
  output logic              irq
);
  localparam int CODE_W = $bits(err_code_e);

  err_vec_t  err_v;
  err_code_e code;
  logic      err_accept;
  logic      succ_evt;
  logic      succ_flag;
  logic      rd_clr;
  logic      any_evt;

  assign err_v   = '{bit0: err_bit0, stuff: err_stuff, crc: err_crc,
                     noack: err_noack, form: err_form, bit1: err_bit1};
  assign rd_clr  = host_rd && !swinit;
  assign any_evt = err_accept || succ_evt;

  err_code_latch u_code (
    .clk(clk), .rst_n(rst_n), .err_v(err_v), .clean_in(frame_clean),
    .rd_clr(rd_clr), .code(code), .accept(err_accept)
  );

  succ_flag_reg u_succ (
    .clk(clk), .rst_n(rst_n), .strobe(succ_strobe), .wr_en(host_wr),
    .wr_bit(host_wdata[SUCC_BIT]), .flag(succ_flag), .evt(succ_evt)
  );

  irq_sticky u_irq (
    .clk(clk), .rst_n(rst_n), .ev(any_evt), .en(irq_en), .rd(host_rd),
    .irq(irq)
  );

  always_comb begin
    host_rdata                = '0;
    host_rdata[CODE_W-1:0]    = code;
    host_rdata[SUCC_BIT]      = succ_flag;
  end
endmodule

// File: rtl/can_err_status_chk.sv
module can_err_status_chk #(
  parameter int DATA_W   = 8,
  parameter int SUCC_BIT = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_rd,
  input logic              swinit,
  input logic              irq_en,
  input logic              succ_strobe,
  input logic              frame_clean,
  input logic [DATA_W-1:0] host_rdata,
  input logic              irq,
  input logic              err_accept,
  input logic              succ_evt
);
  logic [2:0] c;
  logic       busy;
  assign c    = host_rdata[2:0];
  assign busy = (c != 3'b000) && (c != 3'b111);

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(host_rd && !swinit)) |=> $stable(host_rdata[2:0])); // R4
  AST_ACCEPT_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_accept |-> !busy); // R4
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !swinit && !err_accept) |=> (host_rdata[2:0] == 3'b111)); // R3
  AST_SWINIT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && swinit && !err_accept && !frame_clean) |=> $stable(host_rdata[2:0])); // R3
  AST_ACCEPT_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (err_accept && irq_en) |=> irq); // R5
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past((err_accept || succ_evt) && irq_en)); // R5
  AST_SUCC_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    succ_strobe |=> host_rdata[SUCC_BIT]); // R8
  AST_READ_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && !((err_accept || succ_evt) && irq_en)) |=> !irq); // R11
endmodule

bind can_err_status can_err_status_chk #(.DATA_W(DATA_W), .SUCC_BIT(SUCC_BIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .swinit(swinit),
  .irq_en(irq_en), .succ_strobe(succ_strobe), .frame_clean(frame_clean),
  .host_rdata(host_rdata), .irq(irq), .err_accept(err_accept),
  .succ_evt(succ_evt)
);

// File: tb/tb_can_err_status.sv
module tb_can_err_status;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rd = 0, wr = 0, cl = 0, s = 0, swi = 0, en = 1;
  logic [7:0] wd = 0;
  logic [5:0] eb = 0; // {bit0, stuff, crc, noack, form, bit1}
  logic [7:0] rdata;
  logic       irq;
  int         n_chk = 0, n_fail = 0;
  logic [2:0] m_code;
  logic       m_flag, m_irq;

  always #4 clk = ~clk;

  can_err_status dut (
    .clk(clk), .rst_n(rst_n), .host_rd(rd), .host_wr(wr), .host_wdata(wd),
    .host_rdata(rdata), .err_bit0(eb[5]), .err_stuff(eb[4]), .err_crc(eb[3]),
    .err_noack(eb[2]), .err_form(eb[1]), .err_bit1(eb[0]), .frame_clean(cl),
    .succ_strobe(s), .swinit(swi), .irq_en(en), .irq(irq)
  );

  function automatic logic [2:0] exp_code(logic [5:0] e);
    logic [2:0] tbl [6];
    tbl[5] = 3'b101; tbl[4] = 3'b001; tbl[3] = 3'b110;
    tbl[2] = 3'b011; tbl[1] = 3'b010; tbl[0] = 3'b100;
    for (int i = 5; i >= 0; i--) if (e[i]) return tbl[i];
    return 3'b111;
  endfunction

  task automatic model_step();
    logic idle, acc, sev;
    idle = (m_code == 3'b000) || (m_code == 3'b111);
    acc  = (eb != 0) && idle;
    sev  = s || (wr && wd[3] && !m_flag);
    if (!rst_n) begin
      m_code = 3'b111; m_flag = 0; m_irq = 0;
    end else begin
      if (acc)              m_code = exp_code(eb);
      else if (rd && !swi)  m_code = 3'b111;
      else if (cl && idle)  m_code = 3'b000;
      if (s)       m_flag = 1'b1;
      else if (wr) m_flag = wd[3];
      if ((acc || sev) && en) m_irq = 1'b1;
      else if (rd)            m_irq = 1'b0;
    end
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    rd = 0; wr = 0; wd = 0; eb = 0; cl = 0; s = 0;
  endtask

  task automatic cmp(string tag, logic [8:0] act, logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk(string tag, logic [7:0] er, logic ei);
    cmp(tag, {irq, rdata}, {ei, er});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    @(negedge clk);
    tick(); tick(); rst_n = 1;
    chk("R1 reset state", 8'h07, 0);

    eb = 6'b010000; tick();
    chk("R2 stuff code and R5 irq", 8'h01, 1);
    rd = 1; swi = 1; tick(); swi = 0;
    chk("R3 swinit read keeps code, R11 irq cleared", 8'h01, 0);
    eb = 6'b001000; tick();
    chk("R4 busy ignores crc, R5 no irq", 8'h01, 0);
    rd = 1; tick();
    chk("R3 read clears to 111", 8'h07, 0);

    eb = 6'b111111; tick(); chk("R6 all errors -> bit0", 8'h05, 1);
    rd = 1; tick();
    eb = 6'b011010; tick(); chk("R6 stuff over crc/form", 8'h01, 1);
    rd = 1; tick();
    eb = 6'b001101; tick(); chk("R6 crc over noack/bit1", 8'h06, 1);
    rd = 1; tick();
    eb = 6'b000011; tick(); chk("R6 form over bit1", 8'h02, 1);
    rd = 1; tick();
    eb = 6'b000100; tick(); chk("R2 noack code", 8'h03, 1);
    rd = 1; tick();
    eb = 6'b000001; tick(); chk("R2 bit1 code", 8'h04, 1);
    rd = 1; tick();

    cl = 1; tick(); chk("R7 clean frame loads 000 no irq", 8'h00, 0);
    cl = 1; eb = 6'b000010; tick(); chk("R7 error beats clean", 8'h02, 1);
    rd = 1; tick();
    cl = 1; rd = 1; tick(); chk("R7 read beats clean", 8'h07, 0);

    s = 1; tick(); chk("R8 strobe sets flag and irq", 8'h0F, 1);
    rd = 1; tick();
    s = 1; tick(); chk("R8 strobe while set raises irq", 8'h0F, 1);
    rd = 1; tick();
    wr = 1; wd = 8'h00; tick(); chk("R9 write 0 clears, no irq", 8'h07, 0);
    wr = 1; wd = 8'h08; tick(); chk("R9 write 0->1 raises irq", 8'h0F, 1);
    rd = 1; tick();
    wr = 1; wd = 8'h08; tick(); chk("R9 write 1 while set, no irq", 8'h0F, 0);
    wr = 1; wd = 8'h02; s = 1; tick(); chk("R9 strobe beats write 0", 8'h0F, 1);
    rd = 1; tick();
    wr = 1; wd = 8'h0A; tick(); chk("R10 code bits not writable", 8'h0F, 0);
    rd = 1; s = 1; tick(); chk("R11 event with read keeps irq", 8'h0F, 1);
    en = 0; rd = 1; tick();
    eb = 6'b100000; tick(); chk("R5 disabled irq stays low", 8'h0D, 0);
    en = 1; rd = 1; tick();

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r   = $urandom;
      rd  = (r[3:0] < 3);
      wr  = (r[7:4] == 0);
      wd  = r[15:8];
      cl  = (r[19:16] == 1);
      s   = (r[23:20] == 2);
      swi = (r[27:24] == 3);
      en  = (r[30:28] != 0);
      eb  = (r[31] && ($urandom % 3 == 0)) ? 6'($urandom) : 6'b0;
      tick();
      cmp("R2/R4/R6/R8/R11 random vs model", {irq, rdata},
          {m_irq, 4'b0, m_flag, m_code});
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule